// File: doc/BRIEF.md
# Infrared Controller Status Register

This block is the 8-bit status and command register that the host sees in a serial infrared controller. It gathers single-cycle event strobes from the transmitter, the receiver and the FIFO logic into sticky flags, passes a few live receiver conditions straight through, and keeps one software-writable command bit. That bit tells the transmitter a frame is complete. The meaning of two bits depends on the operating mode, either medium/fast IR or remote-control IR. The underrun check uses the software frame-end bit when data moves by PIO, and the DMA terminal count when data moves by DMA.

The host reads the register through a combinational read path, with a one-cycle read strobe. It writes through a write strobe and a data byte. Some flags clear on a read and one flag clears when software writes a 1 to it, so the host must read or write at the correct moments. The transmitter receives the frame-end command as a level. It acknowledges the frame end with a strobe, and that strobe clears the command.

Top module: `ir_status_reg`

## Requirements
- R1: After the asynchronous active-low reset, all sticky flags (bits 7, 6, 4) and the frame-end command (bit 3 and the frameEndCmd output) are 0.
- R2: Bit 7 (flow control active) becomes 1 in the cycle after a flow-control event strobe. A register read clears it to 0.
- R3: When a set event and a read arrive in the same cycle, the flag stays set. This applies to bit 7 and bit 4.
- R4: In PIO mode (dmaMode=0), a transmitter-empty strobe sets bit 6 (underrun) when the frame-end command is 0. It does not set bit 6 when the command is 1.
- R5: In DMA mode (dmaMode=1), a transmitter-empty strobe sets bit 6 unless a terminal-count strobe has arrived since the last frame-end acknowledge or mode change, or arrives in the same cycle.
- R6: Reading the register does not clear bit 6. Bit 6 clears only on a write with data bit 6 equal to 1. A write with data bit 6 equal to 0 leaves it set.
- R7: Bit 5 shows the receiver-busy input in medium/fast mode (modeRemote=0) and the receive-in-process input in remote mode (modeRemote=1).
- R8: Bit 4 is a sticky flag that clears on read. In medium/fast mode the lost-frame-end strobe sets it. In remote mode the remote-pulse strobe sets it. The strobe of the other mode has no effect.
- R9: In PIO mode, a write loads data bit 3 into the frame-end command, and bit 3 and frameEndCmd show it. In DMA mode, bit 3 and frameEndCmd read 0 and writes do not change the command.
- R10: The frame-end command clears to 0 in the cycle after a transmitter frame-end acknowledge, or after any change of modeRemote or dmaMode.
- R11: Bit 1 shows the frame-ends-pending input. Bit 0 is the OR of the receive FIFO and frame-status FIFO timeout inputs. Bit 2 reads 0.
- R12: Writes have no effect on bits 7, 5, 4, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeRemote | input | 1 | 1 = remote-control IR, 0 = medium/fast IR |
| dmaMode | input | 1 | 1 = DMA transfer, 0 = PIO |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value |
| evFlowCtl | input | 1 | Flow-control event strobe |
| evTxEmpty | input | 1 | Transmitter-ran-empty strobe |
| evTcStrobe | input | 1 | DMA terminal-count strobe |
| rxBusy | input | 1 | Receiver busy level |
| rxInProc | input | 1 | Remote receive-in-process level |
| evLostEnd | input | 1 | Lost-frame-end strobe |
| evRemotePulse | input | 1 | Remote pulse detected strobe |
| rxEndsPending | input | 1 | Frame ends held in receive FIFO |
| rxFifoTimeout | input | 1 | Receive FIFO timeout level |
| statFifoTimeout | input | 1 | Frame-status FIFO timeout level |
| txEndAck | input | 1 | Transmitter frame-end acknowledge strobe |
| frameEndCmd | output | 1 | Frame-end command to the transmitter |

## Verification
The hardest case to reach is DMA underrun suppression. A terminal count is remembered across cycles and then dropped by a frame-end acknowledge, so the stimulus must place a terminal-count strobe, an empty strobe, an acknowledge and a second empty strobe in that order. The bench then checks that only the last empty strobe raises underrun. The same-cycle collisions of set and read are also driven on purpose, together with mode switches while the frame-end command is set.

// File: rtl/ir_status_pkg.sv
package ir_status_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_FLOW  = 7;
  localparam int BIT_UNDER = 6;
  localparam int BIT_BUSY  = 5;
  localparam int BIT_EVT4  = 4;
  localparam int BIT_FEND  = 3;
  localparam int BIT_RSV   = 2;
  localparam int BIT_PEND  = 1;
  localparam int BIT_TOUT  = 0;

  typedef struct packed {
    logic clrOnRd;
    logic clrUnder;
    logic fendWr;
    logic fendVal;
    logic fendClr;
    logic tcClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/ir_status_ctrl.sv
module ir_status_ctrl
  import ir_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeRemote,
  input  logic             dmaMode,
  input  logic             regRd,
  input  logic             regWr,
  input  logic [REG_W-1:0] wrData,
  input  logic             txEndAck,
  output ctrlStrobe_t      strb
);
  logic prevRemote, prevDma, modeChg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRemote <= 1'b0;
      prevDma    <= 1'b0;
    end else begin
      prevRemote <= modeRemote;
      prevDma    <= dmaMode;
    end
  end

  assign modeChg = (modeRemote != prevRemote) || (dmaMode != prevDma);

  always_comb begin
    strb          = '0;
    strb.clrOnRd  = regRd;
    strb.clrUnder = regWr && wrData[BIT_UNDER];
    strb.fendWr   = regWr && !dmaMode;
    strb.fendVal  = wrData[BIT_FEND];
    strb.fendClr  = txEndAck || modeChg;
    strb.tcClr    = txEndAck || modeChg;
  end

  // R9: a write in DMA mode must never reach the command bit
  p_no_dma_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    dmaMode |-> !strb.fendWr);
endmodule

// File: rtl/ir_status_dp.sv
module ir_status_dp
  import ir_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic             modeRemote,
  input  logic             dmaMode,
  input  logic             evFlowCtl,
  input  logic             evTxEmpty,
  input  logic             evTcStrobe,
  input  logic             rxBusy,
  input  logic             rxInProc,
  input  logic             evLostEnd,
  input  logic             evRemotePulse,
  input  logic             rxEndsPending,
  input  logic             rxFifoTimeout,
  input  logic             statFifoTimeout,
  output logic [REG_W-1:0] rdData,
  output logic             frameEndCmd
);
  logic flowQ, underQ, evt4Q, fendQ, tcSeenQ;
  logic evt4Set, tcAvail, underSet;

  assign evt4Set  = modeRemote ? evRemotePulse : evLostEnd;
  assign tcAvail  = tcSeenQ || evTcStrobe;
  assign underSet = evTxEmpty && (dmaMode ? !tcAvail : !fendQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flowQ   <= 1'b0;
      underQ  <= 1'b0;
      evt4Q   <= 1'b0;
      fendQ   <= 1'b0;
      tcSeenQ <= 1'b0;
    end else begin
      if (evFlowCtl)         flowQ <= 1'b1;
      else if (strb.clrOnRd) flowQ <= 1'b0;

      if (underSet)           underQ <= 1'b1;
      else if (strb.clrUnder) underQ <= 1'b0;

      if (evt4Set)           evt4Q <= 1'b1;
      else if (strb.clrOnRd) evt4Q <= 1'b0;

      if (strb.fendWr)       fendQ <= strb.fendVal;
      else if (strb.fendClr) fendQ <= 1'b0;

      if (evTcStrobe)      tcSeenQ <= 1'b1;
      else if (strb.tcClr) tcSeenQ <= 1'b0;
    end
  end

  assign frameEndCmd = fendQ && !dmaMode;

  always_comb begin
    rdData            = '0;
    rdData[BIT_FLOW]  = flowQ;
    rdData[BIT_UNDER] = underQ;
    rdData[BIT_BUSY]  = modeRemote ? rxInProc : rxBusy;
    rdData[BIT_EVT4]  = evt4Q;
    rdData[BIT_FEND]  = frameEndCmd;
    rdData[BIT_RSV]   = 1'b0;
    rdData[BIT_PEND]  = rxEndsPending;
    rdData[BIT_TOUT]  = rxFifoTimeout || statFifoTimeout;
  end

  p_flow_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    evFlowCtl |=> flowQ);
  p_flow_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrOnRd && !evFlowCtl |=> !flowQ);
  p_under_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    underQ && !strb.clrUnder |=> underQ);
  p_pio_under_r4: assert property (@(posedge clk) disable iff (!rstN)
    evTxEmpty && !dmaMode && !fendQ |=> underQ);
  p_evt4_mf_r8: assert property (@(posedge clk) disable iff (!rstN)
    !modeRemote && evLostEnd |=> evt4Q);
endmodule

// File: rtl/ir_status_reg.sv
module ir_status_reg
  import ir_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeRemote,
  input  logic             dmaMode,
  input  logic             regRd,
  input  logic             regWr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             evFlowCtl,
  input  logic             evTxEmpty,
  input  logic             evTcStrobe,
  input  logic             rxBusy,
  input  logic             rxInProc,
  input  logic             evLostEnd,
  input  logic             evRemotePulse,
  input  logic             rxEndsPending,
  input  logic             rxFifoTimeout,
  input  logic             statFifoTimeout,
  input  logic             txEndAck,
  output logic             frameEndCmd
);
  ctrlStrobe_t strb;

  ir_status_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .modeRemote(modeRemote), .dmaMode(dmaMode),
    .regRd(regRd), .regWr(regWr), .wrData(wrData), .txEndAck(txEndAck),
    .strb(strb)
  );

  ir_status_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .modeRemote(modeRemote),
    .dmaMode(dmaMode), .evFlowCtl(evFlowCtl), .evTxEmpty(evTxEmpty),
    .evTcStrobe(evTcStrobe), .rxBusy(rxBusy), .rxInProc(rxInProc),
    .evLostEnd(evLostEnd), .evRemotePulse(evRemotePulse),
    .rxEndsPending(rxEndsPending), .rxFifoTimeout(rxFifoTimeout),
    .statFifoTimeout(statFifoTimeout), .rdData(rdData),
    .frameEndCmd(frameEndCmd)
  );

  // R10: acknowledge without a competing write drops the command
  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    txEndAck && !regWr |=> !frameEndCmd);
endmodule

// File: tb/tb_ir_status_reg.sv
module tb_ir_status_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic modeRemote = 0, dmaMode = 0, regRd = 0, regWr = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic evFlowCtl = 0, evTxEmpty = 0, evTcStrobe = 0, rxBusy = 0, rxInProc = 0;
  logic evLostEnd = 0, evRemotePulse = 0, rxEndsPending = 0;
  logic rxFifoTimeout = 0, statFifoTimeout = 0, txEndAck = 0;
  logic frameEndCmd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_status_reg dut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doRead();
    regRd = 1; tick(); regRd = 0;
  endtask

  task automatic doWrite(logic [7:0] d);
    regWr = 1; wrData = d; tick(); regWr = 0; wrData = '0;
  endtask

  task automatic t_reset();
    check("R1 reset value", rdData, 8'h00);
    check("R1 reset command", frameEndCmd, 1'b0);
  endtask

  task automatic t_flow();
    doRead(); check("R2 idle stays clear", rdData[7], 0);
    evFlowCtl = 1; tick(); evFlowCtl = 0;
    check("R2 flow set", rdData[7], 1);
    doRead(); check("R2 flow cleared by read", rdData[7], 0);
  endtask

  task automatic t_setWins();
    evFlowCtl = 1; regRd = 1; tick(); evFlowCtl = 0; regRd = 0;
    check("R3 flow set beats read", rdData[7], 1);
    evLostEnd = 1; regRd = 1; tick(); evLostEnd = 0; regRd = 0;
    check("R3 bit4 set beats read", rdData[4], 1);
    doRead();
    check("R3 both cleared afterwards", rdData & 8'h90, 8'h00);
  endtask

  task automatic t_pioUnder();
    evTxEmpty = 1; tick(); evTxEmpty = 0;
    check("R4 underrun without frame end", rdData[6], 1);
    doRead(); check("R6 read keeps underrun", rdData[6], 1);
    doWrite(8'h00); check("R6 write zero keeps underrun", rdData[6], 1);
    doWrite(8'h40); check("R6 write one clears underrun", rdData[6], 0);
    doWrite(8'h08);
    check("R9 PIO command bit", rdData[3], 1);
    check("R9 PIO command out", frameEndCmd, 1);
    evTxEmpty = 1; tick(); evTxEmpty = 0;
    check("R4 no underrun with frame end", rdData[6], 0);
    txEndAck = 1; tick(); txEndAck = 0;
    check("R10 ack clears command", frameEndCmd, 0);
  endtask

  task automatic t_dmaUnder();
    dmaMode = 1; tick();
    evTxEmpty = 1; tick(); evTxEmpty = 0;
    check("R5 DMA underrun without TC", rdData[6], 1);
    doWrite(8'h40);
    evTcStrobe = 1; tick(); evTcStrobe = 0;
    evTxEmpty = 1; tick(); evTxEmpty = 0;
    check("R5 remembered TC suppresses", rdData[6], 0);
    evTcStrobe = 1; evTxEmpty = 1; tick(); evTcStrobe = 0; evTxEmpty = 0;
    check("R5 same-cycle TC suppresses", rdData[6], 0);
    txEndAck = 1; tick(); txEndAck = 0;
    evTxEmpty = 1; tick(); evTxEmpty = 0;
    check("R5 TC consumed by ack", rdData[6], 1);
    doWrite(8'h48);
    check("R9 DMA bit3 reads 0", rdData[3], 0);
    check("R9 DMA command low", frameEndCmd, 0);
    dmaMode = 0; tick();
    check("R9 DMA write ignored", frameEndCmd, 0);
  endtask

  task automatic t_modeChange();
    doWrite(8'h08); check("R9 command set", frameEndCmd, 1);
    modeRemote = 1; tick();
    check("R10 mode change clears command", frameEndCmd, 0);
    modeRemote = 0; tick();
    doWrite(8'h08); dmaMode = 1; tick(); dmaMode = 0; tick();
    check("R10 DMA toggle clears command", frameEndCmd, 0);
  endtask

  task automatic t_bit5();
    modeRemote = 0; rxBusy = 1; rxInProc = 0; tick();
    check("R7 MF busy", rdData[5], 1);
    rxBusy = 0; rxInProc = 1; tick();
    check("R7 MF ignores in-process", rdData[5], 0);
    modeRemote = 1; tick();
    check("R7 remote in-process", rdData[5], 1);
    rxBusy = 1; rxInProc = 0; tick();
    check("R7 remote ignores busy", rdData[5], 0);
    rxBusy = 0; modeRemote = 0; tick();
  endtask

  task automatic t_bit4();
    evRemotePulse = 1; tick(); evRemotePulse = 0;
    check("R8 MF ignores pulse", rdData[4], 0);
    evLostEnd = 1; tick(); evLostEnd = 0;
    check("R8 MF lost end", rdData[4], 1);
    doRead(); check("R8 MF read clears", rdData[4], 0);
    modeRemote = 1; tick();
    evLostEnd = 1; tick(); evLostEnd = 0;
    check("R8 remote ignores lost end", rdData[4], 0);
    evRemotePulse = 1; tick(); evRemotePulse = 0;
    check("R8 remote pulse", rdData[4], 1);
    doRead(); check("R8 remote read clears", rdData[4], 0);
    modeRemote = 0; tick();
  endtask

  task automatic t_live();
    rxEndsPending = 1; tick();
    check("R11 pending", rdData[2:0], 3'b010);
    rxEndsPending = 0; rxFifoTimeout = 1; tick();
    check("R11 rx timeout", rdData[2:0], 3'b001);
    rxFifoTimeout = 0; statFifoTimeout = 1; tick();
    check("R11 status timeout", rdData[2:0], 3'b001);
    statFifoTimeout = 0; tick();
    check("R11 all clear", rdData[2:0], 3'b000);
  endtask

  task automatic t_roWrites();
    doWrite(8'hB7);
    check("R12 read-only bits unaffected", rdData & 8'hF7, 8'h00);
    evFlowCtl = 1; evLostEnd = 1; tick(); evFlowCtl = 0; evLostEnd = 0;
    doWrite(8'h00);
    check("R12 write zero keeps flags", rdData & 8'h90, 8'h90);
    doRead();
  endtask

  initial begin
    repeat (2) tick();
    t_reset();
    rstN = 1; tick();
    t_flow();
    t_setWins();
    t_pioUnder();
    doWrite(8'h40);
    t_dmaUnder();
    doWrite(8'h40);
    t_modeChange();
    t_bit5();
    t_bit4();
    t_live();
    t_roWrites();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule